// File: doc/BRIEF.md
# Serial Link Wake and Sleep Controller

This block governs when a four-wire time-division serial link (one bit clock, one frame sync, two data lines) is powered down and when it is brought back up. One role input selects the side of the link the block sits on. As clock master it starts and stops the link clock and listens on its data input for a wake request. As clock slave it notices a stopped link clock by timeout and can itself wake the master by pulling its data line low.

All logic runs on a fast free-running reference clock. The link clock and the data input are resynchronised, and the slave's idle timeout is counted in reference cycles, derived from the reference period and the timeout duration given as parameters. A sticky timing-request flag tells the processor that the link needs attention. The flag is cleared by a one-cycle write strobe. The command channel, the framing and the timeslot data all lie outside this block.

Top module: `link_wake_ctrl`

## Requirements
- R1: In master role (`role_slave`=0), `clk_run` and `tx_oe` both equal the value that `act_bit` had at the previous reference clock edge. They are 0 while the activation bit is 0.
- R2: In master role with the link stopped (`act_bit` registered as 0), a low level on `data_in` sets `irq`. When the link is running (`act_bit` registered as 1), a low `data_in` leaves `irq` at 0.
- R3: `irq` stays at 1 until `irq_clr` is pulsed high for a cycle. If a set condition and `irq_clr` occur in the same cycle, `irq` remains 1.
- R4: After reset in slave role (`role_slave`=1), the block is deactivated: `tx_oe`=0, `rx_oe`=0, `drive_low`=0, `clk_run`=0 and `irq`=0.
- R5: In the deactivated slave state, a rising edge on `link_clk` puts the block in the active state (`tx_oe`=1) and sets `irq`. No processor action is needed, and the edge is seen within 4 reference cycles.
- R6: In the active slave state, if no rising `link_clk` edge is detected for TMO_CYC reference cycles (ceil(TIMEOUT_NS*1000/REF_PERIOD_PS), 65 by default), the block returns to the deactivated state (`tx_oe`=0).
- R7: In slave role, `act_bit`=1 drives the master-facing pin low (`rx_oe`=1 and `drive_low`=1) from the next cycle on. This holds in both states and ends only when `act_bit` returns to 0.
- R8: In the active slave state, rising link clock edges spaced closer than TMO_CYC cycles keep the block active.
- R9: In master role `rx_oe` and `drive_low` are always 0. In slave role `clk_run` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_slave | input | 1 | 0 = clock master, 1 = clock slave |
| act_bit | input | 1 | Processor activation control bit |
| irq_clr | input | 1 | One-cycle strobe that clears the timing-request flag |
| link_clk | input | 1 | Link bit clock as seen at the pin (asynchronous) |
| data_in | input | 1 | Level of the block's data input pin (asynchronous) |
| tx_oe | output | 1 | Output enable of the normal transmit data pin |
| rx_oe | output | 1 | Output enable of the master-facing pin, used for the slave wake drive |
| drive_low | output | 1 | Request to drive the enabled master-facing pin low |
| clk_run | output | 1 | Link clock run enable (master role) |
| irq | output | 1 | Sticky timing-request flag |

## Verification
On every cycle the assertions check the following: the flag is sticky and a set beats a clear, the timeout counter never runs past its limit, the master outputs track the registered activation bit, the wake drive follows the bit in slave role, and each role's unused outputs stay idle. Only the bench scenarios can show the complete wake sequences through the synchronisers, both master-started and slave-started. They also cover a clock that toggles without a timeout, deactivation after the link clock stops, and the master-role sweep over every combination of activation bit and data level.

// File: rtl/link_wake_pkg.sv
package link_wake_pkg;

   typedef enum logic {
      LS_IDLE = 1'b0,
      LS_RUN  = 1'b1
   } link_state_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/link_wake_sync.sv
module link_wake_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("link_wake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/link_wake_clkmon.sv
module link_wake_clkmon #(
   parameter int TMO_CYC = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_s,
   input  logic watch_en,
   output logic rise,
   output logic expired
);

   localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
   localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC - 1);

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("link_wake_clkmon: TMO_CYC must be at least 2");
   end

   logic          clk_prev;
   logic [CW-1:0] idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= clk_s;
   end

   assign rise = clk_s & ~clk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idle_cnt <= '0;
      else if (!watch_en || rise) idle_cnt <= '0;
      else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
   end

   assign expired = watch_en & ~rise & (idle_cnt == LIMIT);

   // R6: the idle counter saturates at its limit and never wraps
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt <= LIMIT);

   // R8: a detected edge restarts the idle count
   a_r8_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_en && rise) |=> (idle_cnt == '0));

endmodule

// File: rtl/link_wake_flag.sv
module link_wake_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   // R3: the flag holds until a clear arrives
   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);

   // R3: a set in the same cycle as a clear wins
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag);

endmodule

// File: rtl/link_wake_ctrl.sv
module link_wake_ctrl
   import link_wake_pkg::*;
#(
   parameter int REF_PERIOD_PS = 10000,
   parameter int TIMEOUT_NS    = 650,
   parameter int SYNC_STAGES   = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic role_slave,
   input  logic act_bit,
   input  logic irq_clr,
   input  logic link_clk,
   input  logic data_in,
   output logic tx_oe,
   output logic rx_oe,
   output logic drive_low,
   output logic clk_run,
   output logic irq
);

   localparam int TMO_CYC = int'(ceil_div(TIMEOUT_NS * 1000, REF_PERIOD_PS));

   if (REF_PERIOD_PS < 1) begin : g_bad_period
      $error("link_wake_ctrl: REF_PERIOD_PS must be positive");
   end

   logic        lclk_s;
   logic        din_s;
   logic        act_q;
   logic        lclk_rise;
   logic        idle_expired;
   logic        flag_set;
   link_state_t st_q;
   link_state_t st_d;

   link_wake_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(ref_clk), .rst_n(rst_n), .d_async(link_clk), .q_sync(lclk_s));

   // idle level of the data line is high (pull-up)
   link_wake_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_din (
      .clk(ref_clk), .rst_n(rst_n), .d_async(data_in), .q_sync(din_s));

   link_wake_clkmon #(.TMO_CYC(TMO_CYC)) u_clkmon (
      .clk(ref_clk), .rst_n(rst_n), .clk_s(lclk_s),
      .watch_en(role_slave && (st_q == LS_RUN)),
      .rise(lclk_rise), .expired(idle_expired));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act_bit;
   end

   always_comb begin
      st_d = st_q;
      if (!role_slave)                           st_d = LS_IDLE;
      else if (st_q == LS_IDLE && lclk_rise)     st_d = LS_RUN;
      else if (st_q == LS_RUN  && idle_expired)  st_d = LS_IDLE;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) st_q <= LS_IDLE;
      else        st_q <= st_d;
   end

   assign flag_set = role_slave ? ((st_q == LS_IDLE) && lclk_rise)
                                : (!act_q && !din_s);

   link_wake_flag u_flag (
      .clk(ref_clk), .rst_n(rst_n), .set_req(flag_set),
      .clr_req(irq_clr), .flag(irq));

   assign clk_run   = !role_slave && act_q;
   assign tx_oe     = role_slave ? (st_q == LS_RUN) : act_q;
   assign drive_low = role_slave && act_q;
   assign rx_oe     = role_slave && act_q;

   // R1: master outputs track the activation bit one cycle later
   a_r1_master_follow: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!role_slave && $stable(role_slave)) |=> (clk_run == $past(act_bit) && tx_oe == $past(act_bit)));

   // R7: slave wake drive follows the activation bit
   a_r7_wake_drive: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (role_slave && act_bit) |=> (!role_slave || (rx_oe && drive_low)));

   // R9: role-specific outputs stay idle in the other role
   a_r9_master_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !role_slave |-> (!rx_oe && !drive_low));
   a_r9_slave_no_clk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      role_slave |-> !clk_run);

   // R5: a clock edge while deactivated wakes the slave and raises the flag
   a_r5_remote_wake: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (role_slave && st_q == LS_IDLE && lclk_rise) |=> (!role_slave || (tx_oe && irq)));

   // R6: expiry returns the slave to the deactivated state
   a_r6_expire: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (role_slave && idle_expired) |=> (!role_slave || !tx_oe));

endmodule

// File: tb/link_wake_ctrl_bench.sv
`timescale 1ns/1ps
module link_wake_ctrl_bench;

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic role_slave = 1'b0;
   logic act_bit = 1'b0;
   logic irq_clr = 1'b0;
   logic link_clk = 1'b0;
   logic data_in = 1'b1;
   logic tx_oe, rx_oe, drive_low, clk_run, irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 ref_clk = ~ref_clk;

   link_wake_ctrl u_link_wake_ctrl (
      .ref_clk(ref_clk), .rst_n(rst_n), .role_slave(role_slave),
      .act_bit(act_bit), .irq_clr(irq_clr), .link_clk(link_clk),
      .data_in(data_in), .tx_oe(tx_oe), .rx_oe(rx_oe),
      .drive_low(drive_low), .clk_run(clk_run), .irq(irq));

   task automatic chk(input string tag, input logic got, input logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge ref_clk);
   endtask

   task automatic do_reset(input logic slave);
      @(negedge ref_clk);
      rst_n = 1'b0; role_slave = slave; act_bit = 1'b0; irq_clr = 1'b0;
      link_clk = 1'b0; data_in = 1'b1;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(4);
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0; wait_cyc(1);
   endtask

   initial begin : watchdog
      wait_cyc(20000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // ---------------- master role ----------------
      do_reset(1'b0);
      chk("R1 reset clk_run", clk_run, 1'b0);
      chk("R1 reset tx_oe", tx_oe, 1'b0);
      chk("R9 master rx_oe", rx_oe, 1'b0);
      chk("R3 reset irq", irq, 1'b0);

      // R2 sweep over activation bit and data level
      for (int a = 0; a < 2; a++) begin
         for (int d = 0; d < 2; d++) begin
            act_bit = a[0]; data_in = 1'b1;
            wait_cyc(4);
            pulse_clr();
            data_in = d[0];
            wait_cyc(5);
            chk("R2 sweep irq", irq, (a == 0 && d == 0));
            chk("R1 sweep clk_run", clk_run, a[0]);
            chk("R1 sweep tx_oe", tx_oe, a[0]);
            chk("R9 sweep drive_low", drive_low, 1'b0);
            data_in = 1'b1;
            wait_cyc(4);
            chk("R3 sticky after din high", irq, (a == 0 && d == 0));
            pulse_clr();
            chk("R3 cleared", irq, 1'b0);
         end
      end

      // R1 exact latency: bit rises, outputs follow at next edge
      act_bit = 1'b0; wait_cyc(3);
      act_bit = 1'b1;
      #1 chk("R1 before edge", clk_run, 1'b0);
      wait_cyc(1);
      chk("R1 one edge later", clk_run, 1'b1);

      // R3 set wins over simultaneous clear
      act_bit = 1'b0; data_in = 1'b0;
      wait_cyc(5);
      irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0;
      chk("R3 set wins", irq, 1'b1);
      data_in = 1'b1; wait_cyc(4);
      pulse_clr();
      chk("R3 clear without set", irq, 1'b0);

      // ---------------- slave role ----------------
      do_reset(1'b1);
      chk("R4 tx_oe", tx_oe, 1'b0);
      chk("R4 rx_oe", rx_oe, 1'b0);
      chk("R4 drive_low", drive_low, 1'b0);
      chk("R4 irq", irq, 1'b0);
      chk("R9 slave clk_run", clk_run, 1'b0);

      // R5 remote wake
      link_clk = 1'b1;
      wait_cyc(4);
      chk("R5 tx_oe", tx_oe, 1'b1);
      chk("R5 irq", irq, 1'b1);
      chk("R5 no wake drive", rx_oe, 1'b0);
      pulse_clr();

      // R8 running clock keeps the link active
      for (int p = 0; p < 6; p++) begin
         link_clk = 1'b0; wait_cyc(20);
         link_clk = 1'b1; wait_cyc(20);
         chk("R8 stays active", tx_oe, 1'b1);
      end
      chk("R5 no flag while active", irq, 1'b0);
      link_clk = 1'b0;
      wait_cyc(30);   // ~50 cycles since last rise
      chk("R6 not yet expired", tx_oe, 1'b1);
      wait_cyc(40);   // ~90 cycles since last rise
      chk("R6 expired", tx_oe, 1'b0);
      chk("R9 slave clk_run idle", clk_run, 1'b0);

      // R7 local wake
      pulse_clr();
      act_bit = 1'b1;
      wait_cyc(2);
      chk("R7 rx_oe", rx_oe, 1'b1);
      chk("R7 drive_low", drive_low, 1'b1);
      chk("R7 still deactivated", tx_oe, 1'b0);
      link_clk = 1'b1;
      wait_cyc(4);
      chk("R5 local wake irq", irq, 1'b1);
      chk("R5 local wake tx_oe", tx_oe, 1'b1);
      chk("R7 held after clock", drive_low, 1'b1);
      act_bit = 1'b0;
      wait_cyc(2);
      chk("R7 released drive_low", drive_low, 1'b0);
      chk("R7 released rx_oe", rx_oe, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule